// File: doc/BRIEF.md
# Prescaled Reload Timer Counter

This block is a 16-bit interval timer. A programmable prescaler divides the input clock. Each prescaler tick moves the counter one step, up or down, between zero and a reload limit. When the counter wraps, it raises a one-cycle update strobe. Software configures the timer through a small write port with three addresses. Address 0 is control: run enable, count direction and one-shot mode. Address 1 holds the prescaler divisor. Address 2 holds the reload limit.

The prescaler and reload values are double-buffered. A write lands in a staging register. The value the timer actually uses is a working copy, and it changes only at an update event. An update event is either a natural wrap or a software update request. The software request restarts the prescaler, repositions the counter and refreshes the working copies at once. In one-shot mode the first update event clears the run enable, so the timer stops after one period.

Top module: `reload_timer`

## Requirements
- R1: With control bit 1 at 0 the counter increments by one on each prescaler tick. With control bit 1 at 1 it decrements by one on each tick.
- R2: While control bit 0 (run enable) is 0, the counter output holds its value. `running_o` is 0 in that state.
- R3: With a working divisor of P, a running counter takes one step every P+1 clock cycles. Counting restarts from prescaler phase 0 after any update event.
- R4: Counting up, the count moves from the working reload limit to 0. Counting down, it moves from 0 to the reload limit. Either move is a wrap and an update event.
- R5: `update_o` is high for exactly one cycle per update event. It is high in the same cycle that the count first shows its post-event value.
- R6: With control bit 2 (one-shot) at 1, an update event clears the run enable. After that event `running_o` is 0 and the count stays at the value it was reloaded to.
- R7: A write to address 1 or 2 changes nothing until the next update event. A write made in the very cycle of an update event waits for the event after that one.
- R8: Pulsing `sw_update` for one cycle does four things at once. It clears the prescaler phase. It loads both working copies from staging. It sets the count to 0 when counting up, or to the staged reload value when counting down. It raises `update_o` in the next cycle, and it does all of this whether or not the timer is running.
- R9: A control write in the same cycle as a one-shot update event takes priority over the automatic enable clear.
- R10: After reset the count is 0, `update_o` is 0 and `running_o` is 0. The staged and working reload limits reset to all ones. Both divisors reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 divisor, 2 reload limit |
| wr_data | input | 16 | Write data. Control uses bit 0 enable, bit 1 down, bit 2 one-shot |
| sw_update | input | 1 | Software update request, one cycle |
| count | output | 16 | Current counter value |
| update_o | output | 1 | One-cycle update-event strobe |
| running_o | output | 1 | Run enable as currently held |

## Verification
A software update request can coincide with a natural wrap. The bench provokes this by polling its reference model until the next edge is a wrap, then pulsing `sw_update` for that edge. The check expects a single strobe cycle and the count placed at the software-update position, not a double event. In the same way, the bench aims a reload-limit write at a wrap edge and a control write at a one-shot stop edge. It then judges that the staged value waits one more period and that the written enable survives.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_DIV  = 2'd1,
    RA_LIM  = 2'd2
  } rt_addr_e;

  localparam int unsigned CTL_RUN  = 0;
  localparam int unsigned CTL_DOWN = 1;
  localparam int unsigned CTL_ONCE = 2;
endpackage

// File: rtl/rt_regs.sv
module rt_regs
  import rt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              evt,
  output logic              run,
  output logic              down,
  output logic              once,
  output logic [PSC_W-1:0]  div_act,
  output logic [CNT_W-1:0]  lim_act,
  output logic [CNT_W-1:0]  lim_stg
);
  logic ctrl_wr, div_wr, lim_wr;
  logic run_q, run_d, down_q, down_d, once_q, once_d;
  logic [PSC_W-1:0] div_stg_q, div_stg_d, div_act_q, div_act_d;
  logic [CNT_W-1:0] lim_stg_q, lim_stg_d, lim_act_q, lim_act_d;

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == RA_CTRL);
    div_wr  = wr_en && (wr_addr == RA_DIV);
    lim_wr  = wr_en && (wr_addr == RA_LIM);
    run_d  = run_q;
    down_d = down_q;
    once_d = once_q;
    if (ctrl_wr) begin
      run_d  = wr_data[CTL_RUN];
      down_d = wr_data[CTL_DOWN];
      once_d = wr_data[CTL_ONCE];
    end else if (evt && once_q) begin
      run_d = 1'b0;
    end
    div_stg_d = div_wr ? wr_data[PSC_W-1:0] : div_stg_q;
    lim_stg_d = lim_wr ? wr_data[CNT_W-1:0] : lim_stg_q;
    div_act_d = evt ? div_stg_q : div_act_q;
    lim_act_d = evt ? lim_stg_q : lim_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      down_q    <= 1'b0;
      once_q    <= 1'b0;
      div_stg_q <= '0;
      div_act_q <= '0;
      lim_stg_q <= '1;
      lim_act_q <= '1;
    end else begin
      run_q     <= run_d;
      down_q    <= down_d;
      once_q    <= once_d;
      div_stg_q <= div_stg_d;
      div_act_q <= div_act_d;
      lim_stg_q <= lim_stg_d;
      lim_act_q <= lim_act_d;
    end
  end

  assign run     = run_q;
  assign down    = down_q;
  assign once    = once_q;
  assign div_act = div_act_q;
  assign lim_act = lim_act_q;
  assign lim_stg = lim_stg_q;

  // R6
  once_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && once_q && !ctrl_wr) |=> !run_q);
  // R9
  ctrl_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ctrl_wr && wr_data[CTL_RUN]) |=> run_q);
  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> ($stable(lim_act_q) && $stable(div_act_q)));
endmodule

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] limit,
  output logic             tick
);
  localparam logic [PSC_W-1:0] ONE = PSC_W'(1);
  logic [PSC_W-1:0] ph_q, ph_d;

  always_comb begin
    tick = run && (ph_q == limit);
    ph_d = ph_q;
    if (restart || tick) ph_d = '0;
    else if (run)        ph_d = ph_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // R3
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= limit);
  // R3
  restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ph_q == '0));
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             down,
  input  logic             restart,
  input  logic [CNT_W-1:0] top,
  input  logic [CNT_W-1:0] reload_val,
  output logic             wrap,
  output logic [CNT_W-1:0] count,
  output logic             update_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic upd_q, upd_d, at_edge;

  always_comb begin
    at_edge = down ? (cnt_q == '0) : (cnt_q == top);
    wrap    = tick && at_edge;
    cnt_d   = cnt_q;
    if (restart || wrap) cnt_d = down ? reload_val : '0;
    else if (tick)       cnt_d = down ? (cnt_q - ONE) : (cnt_q + ONE);
    upd_d = restart || wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      upd_q <= upd_d;
    end
  end

  assign count    = cnt_q;
  assign update_o = upd_q;

  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap && !down && !restart) |=> (count == $past(count) + ONE));
  // R1
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap && down && !restart) |=> (count == $past(count) - ONE));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(count));
  // R4
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !down && !restart) |=> (update_o && count == '0));
  // R4
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && down && !restart) |=> (update_o && count == $past(reload_val)));
  // R4
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= top);
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          wr_en,
  input  logic [1:0]                                    wr_addr,
  input  logic [((CNT_W > PSC_W) ? CNT_W : PSC_W)-1:0]  wr_data,
  input  logic                                          sw_update,
  output logic [CNT_W-1:0]                              count,
  output logic                                          update_o,
  output logic                                          running_o
);
  localparam int unsigned DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W;

  logic [1:0] rsync_q;
  logic rst_int_n;
  logic run, down, once, tick, wrap, evt;
  logic [PSC_W-1:0] div_act;
  logic [CNT_W-1:0] lim_act, lim_stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign evt = wrap || sw_update;

  rt_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .evt(evt), .run(run), .down(down), .once(once),
    .div_act(div_act), .lim_act(lim_act), .lim_stg(lim_stg)
  );

  rt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_int_n), .run(run), .restart(sw_update),
    .limit(div_act), .tick(tick)
  );

  rt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .down(down),
    .restart(sw_update), .top(lim_act), .reload_val(lim_stg),
    .wrap(wrap), .count(count), .update_o(update_o)
  );

  assign running_o = run;

  // R6
  once_flag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (update_o && $past(once) && !$past(wr_en)) |-> !running_o);
endmodule

// File: tb/tb_reload_timer.sv
`timescale 1ns/1ps
module tb_reload_timer;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [1:0] wr_addr;
  logic [15:0] wr_data;
  logic sw_update;
  logic [15:0] count;
  logic update_o, running_o;

  always #2 clk = ~clk;

  reload_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sw_update(sw_update), .count(count),
    .update_o(update_o), .running_o(running_o)
  );

  int tests = 0;
  int fails = 0;
  string cur_tag = "R10";
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  int m_en, m_dir, m_once, m_div, m_lim, m_div_w, m_lim_w, m_ph, m_cnt, m_upd;

  always @(posedge clk or negedge rst_n) begin : model
    int tk, wp, ev, clr;
    if (!rst_n) begin
      m_en = 0; m_dir = 0; m_once = 0; m_div = 0; m_div_w = 0;
      m_lim = 65535; m_lim_w = 65535; m_ph = 0; m_cnt = 0; m_upd = 0;
    end else begin
      tk  = (m_en == 1 && m_ph == m_div_w) ? 1 : 0;
      wp  = (tk == 1 && ((m_dir == 1) ? (m_cnt == 0) : (m_cnt == m_lim_w))) ? 1 : 0;
      ev  = (wp == 1 || sw_update) ? 1 : 0;
      clr = (ev == 1 && m_once == 1) ? 1 : 0;
      if (sw_update) m_ph = 0;
      else if (m_en == 1) m_ph = (tk == 1) ? 0 : m_ph + 1;
      if (ev == 1) m_cnt = (m_dir == 1) ? m_lim : 0;
      else if (tk == 1) m_cnt = (m_dir == 1) ? m_cnt - 1 : m_cnt + 1;
      if (ev == 1) begin
        m_div_w = m_div;
        m_lim_w = m_lim;
      end
      m_upd = ev;
      if (wr_en && wr_addr == 2'd1) m_div = int'(wr_data);
      if (wr_en && wr_addr == 2'd2) m_lim = int'(wr_data);
      if (wr_en && wr_addr == 2'd0) begin
        m_en   = int'(wr_data[0]);
        m_dir  = int'(wr_data[1]);
        m_once = int'(wr_data[2]);
      end else if (clr == 1) begin
        m_en = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      tests++;
      if (count !== m_cnt[15:0] || update_o !== m_upd[0] || running_o !== m_en[0]) begin
        fails++;
        $display("FAIL %s per-cycle: count=%0d exp %0d, update=%0b exp %0b, running=%0b exp %0b",
                 cur_tag, count, m_cnt, update_o, m_upd[0], running_o, m_en[0]);
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic swu();
    sw_update = 1'b1;
    @(negedge clk);
    sw_update = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit wrap_next();
    return (m_en == 1 && m_ph == m_div_w &&
            ((m_dir == 1) ? (m_cnt == 0) : (m_cnt == m_lim_w)));
  endfunction

  task automatic to_wrap();
    for (int k = 0; k < 5000 && !wrap_next(); k++) @(negedge clk);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog (all R): ran 200000 cycles, expected completion earlier");
      report();
      $finish;
    end
  end

  initial begin
    int held;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'd0; sw_update = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "count in reset", int'(count), 0);
    chk("R10", "update_o in reset", int'(update_o), 0);
    chk("R10", "running_o in reset", int'(running_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;
    idle(3);

    // R8 software update loads staged values
    cur_tag = "R8";
    wr(2'd2, 16'd4);
    swu();
    chk("R8", "strobe after sw update", int'(update_o), 1);
    chk("R8", "count after sw update (up)", int'(count), 0);

    // R1 / R4 / R5 counting up, divisor 0
    cur_tag = "R1";
    wr(2'd0, 16'd1);
    chk("R5", "strobe drops after one cycle", int'(update_o), 0);
    chk("R1", "running after enable", int'(running_o), 1);
    idle(4);
    chk("R1", "count after four ticks", int'(count), 4);
    cur_tag = "R4";
    idle(1);
    chk("R4", "up wrap to zero", int'(count), 0);
    chk("R4", "strobe on up wrap", int'(update_o), 1);
    idle(1);
    chk("R5", "strobe single cycle", int'(update_o), 0);

    // R3 divisor of 2: one step per 3 cycles
    cur_tag = "R3";
    wr(2'd1, 16'd2);
    swu();
    idle(2);
    chk("R3", "count before third cycle", int'(count), 0);
    idle(1);
    chk("R3", "count at third cycle", int'(count), 1);

    // R7 reload limit buffered until update event
    cur_tag = "R7";
    wr(2'd2, 16'd2);
    to_wrap();
    chk("R7", "old limit still reached", int'(count), 4);
    idle(1);
    chk("R7", "wrap at old limit", int'(count), 0);
    to_wrap();
    chk("R7", "new limit after event", int'(count), 2);

    // R1 / R4 counting down
    cur_tag = "R1";
    wr(2'd0, 16'd3);
    to_wrap();
    chk("R1", "down count reaches zero", int'(count), 0);
    cur_tag = "R4";
    idle(1);
    chk("R4", "down wrap to limit", int'(count), 2);
    chk("R4", "strobe on down wrap", int'(update_o), 1);
    idle(3);
    chk("R1", "down step after divisor period", int'(count), 1);

    // R7 write in the cycle of an update event waits one more event
    cur_tag = "R7";
    to_wrap();
    wr(2'd2, 16'd6);
    chk("R7", "reload uses pre-write stage", int'(count), 2);
    to_wrap();
    idle(1);
    chk("R7", "late write applies next event", int'(count), 6);

    // R8 software update coinciding with a wrap
    cur_tag = "R8";
    to_wrap();
    swu();
    chk("R8", "count on coincident update", int'(count), 6);
    chk("R8", "strobe on coincident update", int'(update_o), 1);
    idle(1);
    chk("R5", "single strobe for coincident update", int'(update_o), 0);

    // R2 disabled counter holds
    cur_tag = "R2";
    wr(2'd0, 16'd2);
    held = int'(count);
    idle(10);
    chk("R2", "count held while disabled", int'(count), held);
    chk("R2", "running low while disabled", int'(running_o), 0);

    // R6 one-shot stop
    cur_tag = "R6";
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd3);
    swu();
    chk("R8", "sw update while stopped, down", int'(count), 3);
    wr(2'd0, 16'd5);
    to_wrap();
    idle(1);
    chk("R6", "one-shot wrap count", int'(count), 0);
    chk("R6", "one-shot clears run", int'(running_o), 0);
    idle(5);
    chk("R6", "count stays after one-shot", int'(count), 0);

    // R9 control write at one-shot stop wins
    cur_tag = "R9";
    wr(2'd0, 16'd5);
    to_wrap();
    wr(2'd0, 16'd5);
    chk("R9", "enable kept by coincident write", int'(running_o), 1);
    idle(2);
    chk("R9", "counter keeps running", int'(count), 2);
    to_wrap();
    idle(1);
    chk("R6", "next one-shot event stops", int'(running_o), 0);

    idle(3);
    done = 1'b1;
    report();
    $finish;
  end
endmodule